// File: doc/BRIEF.md
# Fill-and-Verify Memory Pattern Tester

This block exercises a 32-bit word memory through a simple synchronous port. For each region it tests, it steps through seven data patterns in a fixed order. For each pattern it first writes every word of the region. It then reads every word back and compares it with the value that pattern gives for that word's position in the region. The first mismatching word ends the whole run. The block then reports the failing pattern number, the byte address, the value written and the value returned.

The amount of memory tested comes from an installed-size input. That size is capped and then reduced by one "megabyte" unit, where the unit is a parameter with a default of 1 MiB. Full mode treats the whole tested size as a single region starting at the memory base. Sparse mode tests only two short windows per megabyte unit: one at the bottom of the unit and one that ends at the top of the unit. While the run is in progress, a one-cycle service pulse for an external watchdog is produced at a regular word interval and at the end of every pattern.

Top module: `mem_pattern_tester`

## Requirements
- R1: The patterns run in this order, and a failing pattern is reported by these numbers: 0 = all zeros, 1 = all ones, 2 = 32'h5555_5555, 3 = 32'hAAAA_AAAA, 4 = a single one bit at position (word index mod 32), 5 = the word index, 6 = the bitwise complement of the word index.
- R2: For each pattern, every word of the region is written before any word is read. The expected value comes from the word index counted from 0 at the region start, not from the absolute address.
- R3: The run stops at the first mismatching read, and no later pattern or region is tested after that. On a failure, fail_mode, fail_addr, fail_exp and fail_got hold the pattern number, the byte address, the expected value and the value read.
- R4: wdog_kick pulses for one cycle in each of these cases: for every word written whose index is a multiple of WDOG_EVERY; for every word that reads back correctly whose index is a multiple of WDOG_EVERY; and once at the end of each pattern, whether that pattern passed or failed.
- R5: The tested size is min(mem_size_bytes, CAP_MB units) minus one unit, saturating at zero and rounded down to whole words. If nothing is left to test, the run ends at once with pass and makes no memory access.
- R6: In full mode the single region starts at MEM_BASE and covers the whole tested size. No address at or above MEM_BASE + tested size is accessed.
- R7: In sparse mode, for each unit index i below (tested size / unit), two regions of WIN_BYTES are tested in this order: first the one at MEM_BASE + i·unit, then the one at MEM_BASE + (i+1)·unit − WIN_BYTES. All seven patterns run on each region, and no other address is written.
- R8: A start pulse in idle or done begins a run and clears done, pass and the fail fields. A start pulse while busy has no effect. At the end, done rises together with pass (1 for success, 0 for failure), and all results are held until the next start. After a passing run the fail fields read 0.
- R9: Each cycle carries at most one access. Read data is taken in the cycle after the read request. Addresses are word-aligned, and mem_req is low whenever busy is low.
- R10: After reset, done, pass, busy, mem_req and wdog_kick are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (idle or done only) |
| sparse_mode | input | 1 | 1 = boundary windows only, 0 = whole tested size |
| mem_size_bytes | input | 32 | Installed memory size in bytes |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word-aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| wdog_kick | output | 1 | One-cycle watchdog service pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| pass | output | 1 | Run finished without mismatch |
| fail_mode | output | 3 | Pattern number of the failure |
| fail_addr | output | 32 | Byte address of the failing word |
| fail_exp | output | 32 | Expected value at the failure |
| fail_got | output | 32 | Value read at the failure |

## Verification
A read result is compared in the cycle after its request. Any resulting watchdog pulse is registered and appears one cycle after that. The end-of-pattern pulse comes out in the same cycle that done rises on a failing run. For this reason the bench polls done at falling edges and then waits two more cycles before it reads its write and pulse counters. All memory accesses and pulses are counted by the bench's own memory model at rising edges. The expected counts come from the region size, the pulse interval and the failing word index, using the rules in R4 to R7.

// File: rtl/mtest_pkg.sv
// Shared types for the pattern tester: pattern numbering and sequencer states.
package mtest_pkg;
    typedef enum logic [2:0] {
        PAT_ZERO   = 3'd0,
        PAT_ONES   = 3'd1,
        PAT_FIVES  = 3'd2,
        PAT_AAAS   = 3'd3,
        PAT_WALK   = 3'd4,
        PAT_INDEX  = 3'd5,
        PAT_NINDEX = 3'd6
    } pat_mode_t;

    localparam pat_mode_t PAT_LAST = PAT_NINDEX;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WRITE,
        ST_READ,
        ST_DRAIN,
        ST_MODE_END,
        ST_NEXT,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/mtest_pattern_gen.sv
// Pattern value generator.
// Returns the data word that a given pattern assigns to a region-relative
// word index. Purely combinational; assumes the index counts from 0.
module mtest_pattern_gen
    import mtest_pkg::*;
(
    input  pat_mode_t   mode,
    input  logic [31:0] word_idx,
    output logic [31:0] value
);
    // Select the data for the current pattern and index.
    always_comb begin
        unique case (mode)
            PAT_ZERO:   value = 32'h0000_0000;
            PAT_ONES:   value = 32'hFFFF_FFFF;
            PAT_FIVES:  value = 32'h5555_5555;
            PAT_AAAS:   value = 32'hAAAA_AAAA;
            PAT_WALK:   value = 32'h0000_0001 << word_idx[4:0];
            PAT_INDEX:  value = word_idx;
            PAT_NINDEX: value = ~word_idx;
            default:    value = 32'h0000_0000;
        endcase
    end
endmodule

// File: rtl/mtest_region_plan.sv
// Region planner.
// Turns the latched installed size into the tested size and gives the base
// address and word count of the current region for either test mode.
// Assumes WIN_BYTES is a nonzero multiple of 4 no larger than one unit,
// and that CAP_MB units fit in 32 bits.
module mtest_region_plan #(
    parameter int          MB_LOG2   = 20,
    parameter int          WIN_BYTES = 2048,
    parameter int          CAP_MB    = 256,
    parameter logic [31:0] MEM_BASE  = 32'h0
) (
    input  logic [31:0] size_bytes,
    input  logic        sparse,
    input  logic [31:0] win_idx,
    input  logic        win_hi,
    output logic [31:0] region_base,
    output logic [31:0] region_words,
    output logic [31:0] win_count,
    output logic        empty
);
    localparam logic [32:0] UNIT_BYTES = 33'd1 << MB_LOG2;
    localparam logic [32:0] CAP_BYTES  = 33'(CAP_MB) << MB_LOG2;
    localparam logic [31:0] HI_OFFSET  = 32'(UNIT_BYTES - 33'(WIN_BYTES));
    localparam logic [31:0] WIN_WORDS  = 32'(WIN_BYTES / 4);

    logic [32:0] capped;
    logic [32:0] tested;
    logic [31:0] full_words;

    // Cap the installed size and remove one unit, saturating at zero.
    always_comb begin
        capped     = ({1'b0, size_bytes} > CAP_BYTES) ? CAP_BYTES : {1'b0, size_bytes};
        tested     = (capped > UNIT_BYTES) ? (capped - UNIT_BYTES) : 33'd0;
        full_words = 32'(tested >> 2);
        win_count  = 32'(tested >> MB_LOG2);
    end

    // Pick the region geometry for the active mode.
    always_comb begin
        if (sparse) begin
            region_base  = MEM_BASE + (win_idx << MB_LOG2) + (win_hi ? HI_OFFSET : 32'd0);
            region_words = WIN_WORDS;
            empty        = (win_count == 32'd0);
        end else begin
            region_base  = MEM_BASE;
            region_words = full_words;
            empty        = (full_words == 32'd0);
        end
    end
endmodule

// File: rtl/mem_pattern_tester.sv
// Fill-and-verify memory pattern tester (top).
// Runs seven patterns per region: one write pass, then one read pass that
// compares each word a cycle after its request. The first mismatch ends
// the run. Assumes a synchronous memory returning read data one cycle after
// the request and a power-of-two WDOG_EVERY.
module mem_pattern_tester
    import mtest_pkg::*;
#(
    parameter int          MB_LOG2    = 20,
    parameter int          WIN_BYTES  = 2048,
    parameter int          CAP_MB     = 256,
    parameter logic [31:0] MEM_BASE   = 32'h0,
    parameter int          WDOG_EVERY = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        sparse_mode,
    input  logic [31:0] mem_size_bytes,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        wdog_kick,
    output logic        busy,
    output logic        done,
    output logic        pass,
    output logic [2:0]  fail_mode,
    output logic [31:0] fail_addr,
    output logic [31:0] fail_exp,
    output logic [31:0] fail_got
);
    localparam logic [31:0] WD_MASK = 32'(WDOG_EVERY - 1);

    seq_state_t  state;
    pat_mode_t   mode;
    logic [31:0] idx;
    logic [31:0] win_idx;
    logic        win_hi;
    logic [31:0] cfg_size;
    logic        cfg_sparse;
    logic        failed;

    logic        cmp_valid;
    logic [31:0] cmp_idx;
    logic [31:0] cmp_addr;
    logic [31:0] cmp_exp;

    logic [31:0] region_base;
    logic [31:0] region_words;
    logic [31:0] win_count;
    logic        plan_empty;
    logic [31:0] pat_value;
    logic [31:0] last_idx;

    mtest_region_plan #(
        .MB_LOG2   (MB_LOG2),
        .WIN_BYTES (WIN_BYTES),
        .CAP_MB    (CAP_MB),
        .MEM_BASE  (MEM_BASE)
    ) u_plan (
        .size_bytes   (cfg_size),
        .sparse       (cfg_sparse),
        .win_idx      (win_idx),
        .win_hi       (win_hi),
        .region_base  (region_base),
        .region_words (region_words),
        .win_count    (win_count),
        .empty        (plan_empty)
    );

    mtest_pattern_gen u_pat (
        .mode     (mode),
        .word_idx (idx),
        .value    (pat_value)
    );

    // Drive the memory port from the current state and index.
    always_comb begin
        last_idx  = region_words - 32'd1;
        mem_req   = (state == ST_WRITE) || (state == ST_READ);
        mem_we    = (state == ST_WRITE);
        mem_addr  = region_base + (idx << 2);
        mem_wdata = pat_value;
        busy      = (state != ST_IDLE) && (state != ST_DONE);
    end

    // Sequencer: pass ordering, compare stage, watchdog pulses and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mode       <= PAT_ZERO;
            idx        <= 32'd0;
            win_idx    <= 32'd0;
            win_hi     <= 1'b0;
            cfg_size   <= 32'd0;
            cfg_sparse <= 1'b0;
            failed     <= 1'b0;
            cmp_valid  <= 1'b0;
            cmp_idx    <= 32'd0;
            cmp_addr   <= 32'd0;
            cmp_exp    <= 32'd0;
            wdog_kick  <= 1'b0;
            done       <= 1'b0;
            pass       <= 1'b0;
            fail_mode  <= 3'd0;
            fail_addr  <= 32'd0;
            fail_exp   <= 32'd0;
            fail_got   <= 32'd0;
        end else begin
            wdog_kick <= 1'b0;
            cmp_valid <= 1'b0;
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        cfg_size   <= mem_size_bytes;
                        cfg_sparse <= sparse_mode;
                        done       <= 1'b0;
                        pass       <= 1'b0;
                        failed     <= 1'b0;
                        fail_mode  <= 3'd0;
                        fail_addr  <= 32'd0;
                        fail_exp   <= 32'd0;
                        fail_got   <= 32'd0;
                        mode       <= PAT_ZERO;
                        idx        <= 32'd0;
                        win_idx    <= 32'd0;
                        win_hi     <= 1'b0;
                        state      <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (plan_empty) begin
                        state <= ST_DONE;
                        done  <= 1'b1;
                        pass  <= 1'b1;
                    end else begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if ((idx & WD_MASK) == 32'd0) wdog_kick <= 1'b1;
                    if (idx == last_idx) begin
                        idx   <= 32'd0;
                        state <= ST_READ;
                    end else begin
                        idx <= idx + 32'd1;
                    end
                end
                ST_READ: begin
                    cmp_valid <= 1'b1;
                    cmp_idx   <= idx;
                    cmp_addr  <= mem_addr;
                    cmp_exp   <= pat_value;
                    if (idx == last_idx) state <= ST_DRAIN;
                    else                 idx   <= idx + 32'd1;
                end
                ST_DRAIN: begin
                    state <= ST_MODE_END;
                end
                ST_MODE_END: begin
                    wdog_kick <= 1'b1;
                    idx       <= 32'd0;
                    if (failed) begin
                        state <= ST_DONE;
                        done  <= 1'b1;
                        pass  <= 1'b0;
                    end else if (mode == PAT_LAST) begin
                        state <= ST_NEXT;
                    end else begin
                        mode  <= pat_mode_t'(mode + 3'd1);
                        state <= ST_WRITE;
                    end
                end
                ST_NEXT: begin
                    mode <= PAT_ZERO;
                    idx  <= 32'd0;
                    if (!cfg_sparse) begin
                        state <= ST_DONE;
                        done  <= 1'b1;
                        pass  <= 1'b1;
                    end else if (!win_hi) begin
                        win_hi <= 1'b1;
                        state  <= ST_WRITE;
                    end else if (win_idx + 32'd1 >= win_count) begin
                        state <= ST_DONE;
                        done  <= 1'b1;
                        pass  <= 1'b1;
                    end else begin
                        win_idx <= win_idx + 32'd1;
                        win_hi  <= 1'b0;
                        state   <= ST_WRITE;
                    end
                end
                default: state <= ST_IDLE;
            endcase

            if (cmp_valid) begin
                if (mem_rdata != cmp_exp) begin
                    failed    <= 1'b1;
                    fail_mode <= mode;
                    fail_addr <= cmp_addr;
                    fail_exp  <= cmp_exp;
                    fail_got  <= mem_rdata;
                    cmp_valid <= 1'b0;
                    state     <= ST_MODE_END;
                end else if ((cmp_idx & WD_MASK) == 32'd0) begin
                    wdog_kick <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mtest_seq_sva.sv
// Property checker for the pattern tester, bound to every instance of the top.
module mtest_seq_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        pass,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic [2:0]  fail_mode,
    input logic [31:0] fail_addr,
    input logic [31:0] fail_got
);
    AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> (mem_addr[1:0] == 2'b00)); // R9
    AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
    AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) pass |-> done); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> (done && $stable(fail_addr) && $stable(fail_got) && $stable(fail_mode))); // R8
    AST_MODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (done && !pass) |-> (fail_mode <= 3'd6)); // R1
endmodule

bind mem_pattern_tester mtest_seq_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .fail_mode (fail_mode),
    .fail_addr (fail_addr),
    .fail_got  (fail_got)
);

// File: tb/mem_pattern_tester_tb.sv
module mem_pattern_tester_tb;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 256;
    localparam int WIN        = 32;
    localparam int TESTED_MAX = 768;

    typedef struct packed {
        logic        sparse;
        logic [31:0] msize;
        logic [31:0] faddr;
        logic [31:0] ftrig;
        logic [31:0] fmask;
        logic        pass;
        logic [2:0]  mode;
        logic [31:0] addr;
        logic [31:0] expv;
        logic [31:0] got;
        logic [31:0] writes;
        logic [31:0] kicks;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'd1024, 32'd0,   32'h0,        32'h0,        1'b1, 3'd0, 32'd0,   32'h0,        32'h0,        32'd1344, 32'd175},
        '{1'b0, 32'd4096, 32'd0,   32'h0,        32'h0,        1'b1, 3'd0, 32'd0,   32'h0,        32'h0,        32'd1344, 32'd175},
        '{1'b0, 32'd302,  32'd0,   32'h0,        32'h0,        1'b1, 3'd0, 32'd0,   32'h0,        32'h0,        32'd77,   32'd21},
        '{1'b0, 32'd256,  32'd0,   32'h0,        32'h0,        1'b1, 3'd0, 32'd0,   32'h0,        32'h0,        32'd0,    32'd0},
        '{1'b0, 32'd1024, 32'd40,  32'h0,        32'h8,        1'b0, 3'd0, 32'd40,  32'h0,        32'h8,        32'd192,  32'd14},
        '{1'b0, 32'd1024, 32'd148, 32'h20,       32'h1,        1'b0, 3'd4, 32'd148, 32'h20,       32'h21,       32'd960,  32'd116},
        '{1'b0, 32'd1024, 32'd148, 32'd37,       32'h80000000, 1'b0, 3'd5, 32'd148, 32'd37,       32'h80000025, 32'd1152, 32'd141},
        '{1'b0, 32'd1024, 32'd148, 32'hFFFFFFDA, 32'h100,      1'b0, 3'd6, 32'd148, 32'hFFFFFFDA, 32'hFFFFFEDA, 32'd1344, 32'd166},
        '{1'b1, 32'd1024, 32'd0,   32'h0,        32'h0,        1'b1, 3'd0, 32'd0,   32'h0,        32'h0,        32'd336,  32'd126},
        '{1'b1, 32'd1024, 32'd484, 32'h1,        32'h10,       1'b0, 3'd5, 32'd484, 32'h1,        32'h11,       32'd216,  32'd81},
        '{1'b1, 32'd256,  32'd0,   32'h0,        32'h0,        1'b1, 3'd0, 32'd0,   32'h0,        32'h0,        32'd0,    32'd0},
        '{1'b0, 32'd1023, 32'd0,   32'h0,        32'h0,        1'b1, 3'd0, 32'd0,   32'h0,        32'h0,        32'd1337, 32'd175}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sparse_mode = 1'b0;
    logic [31:0] mem_size_bytes = 32'd0;
    logic        mem_req, mem_we, wdog_kick, busy, done, pass;
    logic [31:0] mem_addr, mem_wdata, fail_addr, fail_exp, fail_got;
    logic [31:0] mem_rdata = 32'd0;
    logic [2:0]  fail_mode;

    logic [31:0] ram [256];
    logic [31:0] f_addr = 32'd0, f_trig = 32'd0, f_mask = 32'd0;
    int n_wr = 0, n_kick = 0, n_high = 0, n_outwin = 0, n_rd_idle = 0;
    int checks = 0, errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_pattern_tester #(
        .MB_LOG2    (8),
        .WIN_BYTES  (WIN),
        .CAP_MB     (4),
        .MEM_BASE   (32'h0),
        .WDOG_EVERY (16)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .sparse_mode    (sparse_mode),
        .mem_size_bytes (mem_size_bytes),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_rdata      (mem_rdata),
        .wdog_kick      (wdog_kick),
        .busy           (busy),
        .done           (done),
        .pass           (pass),
        .fail_mode      (fail_mode),
        .fail_addr      (fail_addr),
        .fail_exp       (fail_exp),
        .fail_got       (fail_got)
    );

    // Memory model with one-cycle read latency and a data-dependent read fault.
    always @(posedge clk) begin
        if (mem_req && mem_we) ram[mem_addr[9:2]] <= mem_wdata;
        if (mem_req && !mem_we) begin
            if (f_mask != 0 && mem_addr == f_addr && ram[mem_addr[9:2]] == f_trig)
                mem_rdata <= ram[mem_addr[9:2]] ^ f_mask;
            else
                mem_rdata <= ram[mem_addr[9:2]];
        end
    end

    // Access and pulse counters.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (wdog_kick) n_kick <= n_kick + 1;
        if (mem_req && !busy) n_rd_idle <= n_rd_idle + 1;
        if (mem_req && mem_we) begin
            n_wr <= n_wr + 1;
            if (mem_addr >= TESTED_MAX) n_high <= n_high + 1;
            if ((mem_addr % UNIT) >= WIN && (mem_addr % UNIT) < UNIT - WIN) n_outwin <= n_outwin + 1;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic launch(input logic sp, input logic [31:0] sz, input int extra_start_at);
        int guard;
        sparse_mode    = sp;
        mem_size_bytes = sz;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        guard = 0;
        while (!done) begin
            @(negedge clk);
            guard++;
            if (guard == extra_start_at) start = 1'b1;
            else start = 1'b0;
            if (guard > 20000) begin
                checks++;
                errors++;
                $display("FAIL R8 run never finished: actual busy expected done");
                finish_run();
            end
        end
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Global watchdog.
    initial begin
        wait (cycles > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
        finish_run();
    end

    initial begin
        int w0, k0, h0, o0;
        for (int i = 0; i < 256; i++) ram[i] = 32'hDEAD0000 + i;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "done", {31'd0, done}, 32'd0);
        check("R10", "pass", {31'd0, pass}, 32'd0);
        check("R10", "busy", {31'd0, busy}, 32'd0);
        check("R10", "mem_req", {31'd0, mem_req}, 32'd0);
        check("R10", "wdog_kick", {31'd0, wdog_kick}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 outcomes
        for (int v = 0; v < NVEC; v++) begin
            f_addr = VECS[v].faddr;
            f_trig = VECS[v].ftrig;
            f_mask = VECS[v].fmask;
            w0 = n_wr; k0 = n_kick; h0 = n_high; o0 = n_outwin;
            launch(VECS[v].sparse, VECS[v].msize, -1);
            check("R3", $sformatf("vec%0d pass", v), {31'd0, pass}, {31'd0, VECS[v].pass});
            check("R1", $sformatf("vec%0d fail_mode", v), {29'd0, fail_mode}, {29'd0, VECS[v].mode});
            check("R3", $sformatf("vec%0d fail_addr", v), fail_addr, VECS[v].addr);
            check("R2", $sformatf("vec%0d fail_exp", v), fail_exp, VECS[v].expv);
            check("R3", $sformatf("vec%0d fail_got", v), fail_got, VECS[v].got);
            check("R5", $sformatf("vec%0d writes", v), 32'(n_wr - w0), VECS[v].writes);
            check("R4", $sformatf("vec%0d kicks", v), 32'(n_kick - k0), VECS[v].kicks);
            if (!VECS[v].sparse) check("R6", $sformatf("vec%0d writes past tested size", v), 32'(n_high - h0), 32'd0);
            else check("R7", $sformatf("vec%0d writes outside windows", v), 32'(n_outwin - o0), 32'd0);
        end

        // R8: start while busy is ignored
        f_mask = 32'd0;
        w0 = n_wr; k0 = n_kick;
        launch(1'b0, 32'd302, 20);
        check("R8", "writes with extra start", 32'(n_wr - w0), 32'd77);
        check("R8", "kicks with extra start", 32'(n_kick - k0), 32'd21);
        check("R8", "pass with extra start", {31'd0, pass}, 32'd1);

        // R8: results held while idle after a failing run
        f_addr = 32'd40; f_trig = 32'h0; f_mask = 32'h8;
        launch(1'b0, 32'd1024, -1);
        f_mask = 32'd0;
        repeat (12) @(negedge clk);
        check("R8", "done held", {31'd0, done}, 32'd1);
        check("R8", "fail_addr held", fail_addr, 32'd40);
        check("R8", "fail_got held", fail_got, 32'h8);

        // R8: a new start clears the previous failure
        launch(1'b0, 32'd302, -1);
        check("R8", "pass after rerun", {31'd0, pass}, 32'd1);
        check("R8", "fail_got cleared", fail_got, 32'd0);

        // R5: size below one unit tests nothing
        w0 = n_wr; k0 = n_kick;
        launch(1'b0, 32'd100, -1);
        check("R5", "small size pass", {31'd0, pass}, 32'd1);
        check("R5", "small size writes", 32'(n_wr - w0), 32'd0);
        check("R5", "small size kicks", 32'(n_kick - k0), 32'd0);

        // R9: no access while idle
        check("R9", "accesses while not busy", 32'(n_rd_idle), 32'd0);

        finish_run();
    end
endmodule